// File: doc/BRIEF.md
# Burst Read Bus Responder

This block is the device side of a search-memory slave that shares a wide host bus with other slaves. The bus changes direction between host and device. The host places a read command on a three-bit command field, qualified by a command-valid strobe. In the same cycle it places a device ID and a target selector on the 68-bit data bus. A device whose ID matches accepts the command. An all-ones ID instead selects the single device whose last-in-chain flag is set. The accepted device then runs a burst from its data array or its mask array.

The start location and the burst length are not part of the command. They are loaded beforehand into an internal burst register. The 15-bit location counter advances once per access and keeps its value between bursts. After a two-cycle turnaround, each access takes a pair of cycles: a filler cycle with acknowledge low, then a data cycle with acknowledge high. End-of-transfer rises with the last word. A final cycle drives acknowledge and end-of-transfer low with the data bus released. A burst of n accesses therefore occupies 4 + 2n cycles, counting the command cycle as cycle 1.

Every output has its own output-enable, which models the three-state drivers. The two internal arrays are small memories of parameterised depth. They are written through a preload port.

Top module: `burst_read_responder`

## Requirements
- R1: A command is accepted only when the block is idle and cmd_valid=1, cmd[1:0]=2'b00 (read), cmd[2]=1 (burst), and dq_in[20] is 0. Any other command code, or target code 2'b10 or 2'b11 in dq_in[20:19], produces no output enable.
- R2: The device is selected when dq_in[25:21] equals dev_id, or when dq_in[25:21]=5'b11111 and last_dev=1. A device that is not selected keeps dq_oe, ack_oe and eot_oe low for the whole operation.
- R3: In cycles 2 and 3 after acceptance, dq_oe, ack_oe and eot_oe are all low.
- R4: From cycle 4, accesses run in pairs of cycles. The first cycle of a pair drives the data bus with all ones, with ack low and eot low. The second drives the word at the current location, with ack high. The word comes from the data array when the command carried dq_in[19]=0 and from the mask array when dq_in[19]=1.
- R5: eot_out is driven high only in the data cycle of the last access, and exactly once per burst.
- R6: Cycle 4+2n has dq_oe low, with ack and eot driven low. From cycle 5+2n all three enables are low and a new command may be accepted. All enables are low after reset.
- R7: The 15-bit location counter advances by one after each access and wraps from 0x7FFF to 0. It keeps its value across bursts. Command bits outside [25:19] have no effect. An array word is addressed by the low log2(DEPTH) bits of the counter.
- R8: A burst length of zero performs exactly one access (total 6 cycles).
- R9: While a burst is in progress, cmd_valid is ignored.
- R10: cfg_load while idle loads the location counter from cfg_addr and the burst length from cfg_len. cfg_load during a burst has no effect.
- R11: pre_we writes pre_data at pre_idx into the mask array when pre_mask=1, and into the data array otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd | input | 3 | Command code; bit 2 marks a burst |
| dq_in | input | 68 | Host-driven data bus: ID in [25:21], target in [20:19] |
| dev_id | input | 5 | This device's ID |
| last_dev | input | 1 | Marks the last device in the chain |
| cfg_load | input | 1 | Load burst register |
| cfg_addr | input | 15 | Burst start location |
| cfg_len | input | LEN_W | Burst length (0 means 1) |
| pre_we | input | 1 | Array preload write enable |
| pre_mask | input | 1 | Preload target: 1 mask array, 0 data array |
| pre_idx | input | IDX_W | Preload word index |
| pre_data | input | 68 | Preload word |
| dq_out | output | 68 | Device-driven data bus value |
| dq_oe | output | 1 | Data bus output enable |
| ack_out | output | 1 | Acknowledge value |
| ack_oe | output | 1 | Acknowledge output enable |
| eot_out | output | 1 | End-of-transfer value |
| eot_oe | output | 1 | End-of-transfer output enable |

## Verification
The assertions check the following on every cycle:
- the bus stays quiet in the first cycle after acceptance;
- the data bus is never driven without acknowledge;
- acknowledge alternates;
- end-of-transfer appears only with a high acknowledge, and never twice in a row;
- the released lines were last driven low;
- the number of acknowledged words equals the programmed length when the burst reaches its final cycle;
- no command is accepted mid-burst.

Only the bench scenarios can show the actual word values from each array, the location wrap and its persistence between bursts, and ID and broadcast selection. They also cover rejected command codes and configuration writes ignored during a burst. These scenarios are compared against a cycle-counting model.

// File: rtl/brr_pkg.sv
package brr_pkg;
  localparam int DQ_W   = 68;
  localparam int ID_W   = 5;
  localparam int ADDR_W = 15;
  localparam int TGT_LSB = 19;
  localparam int ID_LSB  = 21;
  localparam int SEL_W   = ID_W + 2;

  localparam logic [1:0] CMD_READ = 2'b00;

  typedef enum logic [2:0] {
    ST_IDLE, ST_TA1, ST_TA2, ST_LO, ST_HI, ST_TAIL
  } seq_t;

  function automatic logic id_hit(input logic [ID_W-1:0] field,
                                  input logic [ID_W-1:0] own,
                                  input logic last);
    if (field == {ID_W{1'b1}}) return last;
    return field == own;
  endfunction

  function automatic logic [ADDR_W-1:0] addr_step(input logic [ADDR_W-1:0] a);
    return a + 1'b1;
  endfunction
endpackage

// File: rtl/brr_decode.sv
module brr_decode
  import brr_pkg::*;
(
  input  logic             idle,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd,
  input  logic [SEL_W-1:0] sel_field,
  input  logic [ID_W-1:0]  dev_id,
  input  logic             last_dev,
  output logic             accept,
  output logic             tgt_mask
);
  logic [ID_W-1:0] id_field;
  logic [1:0]      tgt_field;
  logic            read_ok, id_ok, tgt_ok;

  assign id_field  = sel_field[SEL_W-1:2];
  assign tgt_field = sel_field[1:0];
  assign read_ok   = cmd_valid && cmd[2] && (cmd[1:0] == CMD_READ);
  assign id_ok     = id_hit(id_field, dev_id, last_dev);
  assign tgt_ok    = !tgt_field[1];
  assign accept    = idle && read_ok && id_ok && tgt_ok;
  assign tgt_mask  = tgt_field[0];
endmodule

// File: rtl/brr_seq.sv
module brr_seq
  import brr_pkg::*;
#(
  parameter int LEN_W = 4,
  localparam int CNT_W = LEN_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [LEN_W-1:0] len,
  output seq_t             state,
  output logic             idle,
  output logic             access_done,
  output logic             last_beat,
  output logic [CNT_W-1:0] burst_total
);
  logic [CNT_W-1:0] rem_q;

  function automatic logic [CNT_W-1:0] beat_total(input logic [LEN_W-1:0] l);
    if (l == '0) return CNT_W'(1);
    return CNT_W'(l);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      rem_q       <= '0;
      burst_total <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          state       <= ST_TA1;
          rem_q       <= beat_total(len);
          burst_total <= beat_total(len);
        end
        ST_TA1: state <= ST_TA2;
        ST_TA2: state <= ST_LO;
        ST_LO:  state <= ST_HI;
        ST_HI: begin
          if (rem_q == CNT_W'(1)) state <= ST_TAIL;
          else begin
            rem_q <= rem_q - 1'b1;
            state <= ST_LO;
          end
        end
        ST_TAIL: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign idle        = (state == ST_IDLE);
  assign access_done = (state == ST_HI);
  assign last_beat   = (state == ST_HI) && (rem_q == CNT_W'(1));

  AST_REM_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LO || state == ST_HI) |-> rem_q != '0); // R8
endmodule

// File: rtl/brr_array.sv
module brr_array
  import brr_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic             wr_mask,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [DQ_W-1:0]  wr_data,
  input  logic             rd_mask,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [DQ_W-1:0]  rd_data
);
  logic [DQ_W-1:0] bank_word [2];

  for (genvar g = 0; g < 2; g++) begin : g_bank
    logic [DQ_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (wr_en && (wr_mask == g[0])) mem[wr_idx] <= wr_data;
    end
    assign bank_word[g] = mem[rd_idx];
  end

  assign rd_data = bank_word[rd_mask];
endmodule

// File: rtl/burst_read_responder.sv
module burst_read_responder
  import brr_pkg::*;
#(
  parameter int LEN_W = 4,
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd,
  input  logic [DQ_W-1:0]  dq_in,
  input  logic [ID_W-1:0]  dev_id,
  input  logic             last_dev,
  input  logic             cfg_load,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic             pre_we,
  input  logic             pre_mask,
  input  logic [IDX_W-1:0] pre_idx,
  input  logic [DQ_W-1:0]  pre_data,
  output logic [DQ_W-1:0]  dq_out,
  output logic             dq_oe,
  output logic             ack_out,
  output logic             ack_oe,
  output logic             eot_out,
  output logic             eot_oe
);
  localparam int CNT_W = LEN_W + 1;

  seq_t             state;
  logic             idle, accept, tgt_mask, access_done, last_beat;
  logic [CNT_W-1:0] burst_total;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0] len_q;
  logic             mask_q;
  logic [DQ_W-1:0]  rd_word;
  logic             unused_dq;

  assign unused_dq = ^{dq_in[DQ_W-1:ID_LSB+ID_W], dq_in[TGT_LSB-1:0]};

  brr_decode u_decode (
    .idle      (idle),
    .cmd_valid (cmd_valid),
    .cmd       (cmd),
    .sel_field (dq_in[ID_LSB+ID_W-1:TGT_LSB]),
    .dev_id    (dev_id),
    .last_dev  (last_dev),
    .accept    (accept),
    .tgt_mask  (tgt_mask)
  );

  brr_seq #(.LEN_W(LEN_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept      (accept),
    .len         (len_q),
    .state       (state),
    .idle        (idle),
    .access_done (access_done),
    .last_beat   (last_beat),
    .burst_total (burst_total)
  );

  brr_array #(.DEPTH(DEPTH)) u_array (
    .clk     (clk),
    .wr_en   (pre_we),
    .wr_mask (pre_mask),
    .wr_idx  (pre_idx),
    .wr_data (pre_data),
    .rd_mask (mask_q),
    .rd_idx  (addr_q[IDX_W-1:0]),
    .rd_data (rd_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      len_q  <= '0;
      mask_q <= 1'b0;
    end else begin
      if (idle && cfg_load) begin
        addr_q <= cfg_addr;
        len_q  <= cfg_len;
      end else if (access_done) begin
        addr_q <= addr_step(addr_q);
      end
      if (accept) mask_q <= tgt_mask;
    end
  end

  always_comb begin
    dq_oe   = (state == ST_LO) || (state == ST_HI);
    ack_oe  = dq_oe || (state == ST_TAIL);
    eot_oe  = ack_oe;
    ack_out = (state == ST_HI);
    eot_out = last_beat;
    dq_out  = (state == ST_HI) ? rd_word : {DQ_W{1'b1}};
  end

  // words acknowledged on the bus since the last acceptance
  logic [CNT_W-1:0] beats_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) beats_q <= '0;
    else if (accept) beats_q <= '0;
    else if (ack_oe && ack_out) beats_q <= beats_q + 1'b1;
  end

  AST_ACCEPT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !dq_oe && !ack_oe && !eot_oe); // R3
  AST_DQ_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> ack_oe && eot_oe); // R4
  AST_ACK_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_oe && ack_out) |=> !ack_out); // R4
  AST_EOT_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (eot_oe && eot_out) |-> ack_out); // R5
  AST_EOT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (eot_oe && eot_out) |=> !eot_out); // R5
  AST_RELEASE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_oe) |-> $past(!ack_out && !eot_out && !dq_oe)); // R6
  AST_BEAT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_oe && !dq_oe) |-> beats_q == burst_total); // R8
  AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe || ack_oe) |-> !accept); // R9
endmodule

// File: tb/tb_burst_read_responder.sv
module tb_burst_read_responder;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W = 4;
  localparam int DEPTH = 16;
  localparam int IDX_W = $clog2(DEPTH);
  localparam logic [4:0] MY_ID = 5'h0A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd = '0;
  logic [67:0] dq_in = '0;
  logic [4:0] dev_id = MY_ID;
  logic last_dev = 1'b0;
  logic cfg_load = 1'b0;
  logic [14:0] cfg_addr = '0;
  logic [LEN_W-1:0] cfg_len = '0;
  logic pre_we = 1'b0, pre_mask = 1'b0;
  logic [IDX_W-1:0] pre_idx = '0;
  logic [67:0] pre_data = '0;
  logic [67:0] dq_out;
  logic dq_oe, ack_out, ack_oe, eot_out, eot_oe;

  int checks = 0, errors = 0;
  bit done = 0;
  string cur_tag = "R6 reset";

  burst_read_responder #(.LEN_W(LEN_W), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd), .dq_in(dq_in),
    .dev_id(dev_id), .last_dev(last_dev), .cfg_load(cfg_load), .cfg_addr(cfg_addr),
    .cfg_len(cfg_len), .pre_we(pre_we), .pre_mask(pre_mask), .pre_idx(pre_idx),
    .pre_data(pre_data), .dq_out(dq_out), .dq_oe(dq_oe), .ack_out(ack_out),
    .ack_oe(ack_oe), .eot_out(eot_out), .eot_oe(eot_oe));

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  logic [67:0] ref_dat [DEPTH];
  logic [67:0] ref_msk [DEPTH];
  bit m_busy = 0;
  int m_k = 0, m_n = 1, m_addr = 0, m_len = 0;
  bit m_mask = 0;
  int ack_pulses = 0;

  function automatic bit sel_ok(logic [67:0] d);
    if (d[25:21] == 5'h1F) return last_dev;
    return d[25:21] == dev_id;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_addr = 0; m_len = 0;
    end else if (m_busy) begin
      if ((m_k % 2) == 1 && m_k >= 5 && m_k <= 3 + 2*m_n) m_addr = (m_addr + 1) % 32768;
      m_k++;
      if (m_k > 4 + 2*m_n) m_busy = 0;
    end else begin
      if (cmd_valid && cmd == 3'b100 && !dq_in[20] && sel_ok(dq_in)) begin
        m_busy = 1; m_k = 2; m_n = (m_len == 0) ? 1 : m_len; m_mask = dq_in[19];
      end
      if (cfg_load) begin m_addr = cfg_addr; m_len = cfg_len; end
    end
  end

  task automatic fail(string ph, string what, logic [67:0] act, logic [67:0] exp);
    errors++;
    $display("FAIL %s (%s) k=%0d %s: actual %h expected %h", cur_tag, ph, m_k, what, act, exp);
  endtask

  always @(negedge clk) begin
    if (!done) begin
      logic e_dq_oe, e_ack_oe, e_ack, e_eot;
      logic [67:0] e_dq;
      string ph;
      int idx;
      e_dq_oe = 0; e_ack_oe = 0; e_ack = 0; e_eot = 0; e_dq = '1; ph = "R2 idle";
      idx = m_addr % DEPTH;
      if (m_busy) begin
        if (m_k <= 3) ph = "R3";
        else if (m_k <= 3 + 2*m_n) begin
          e_dq_oe = 1; e_ack_oe = 1;
          if (m_k % 2 == 1) begin
            ph = "R4/R7 data"; e_ack = 1; e_eot = (m_k == 3 + 2*m_n);
            e_dq = m_mask ? ref_msk[idx] : ref_dat[idx];
          end else ph = "R4 filler";
        end else begin ph = "R6 tail"; e_ack_oe = 1; end
      end
      checks++;
      if (dq_oe !== e_dq_oe || ack_oe !== e_ack_oe || eot_oe !== e_ack_oe)
        fail(ph, "enables dq/ack/eot", {65'd0, dq_oe, ack_oe, eot_oe}, {65'd0, e_dq_oe, e_ack_oe, e_ack_oe});
      else if (e_ack_oe && (ack_out !== e_ack || eot_out !== e_eot))
        fail(e_eot ? "R5" : ph, "ack/eot", {66'd0, ack_out, eot_out}, {66'd0, e_ack, e_eot});
      else if (e_dq_oe && dq_out !== e_dq)
        fail(ph, "dq", dq_out, e_dq);
      if (ack_oe && ack_out) ack_pulses++;
    end
  end

  function automatic logic [67:0] mk_dq(logic [4:0] id, logic [1:0] tgt, logic [31:0] fill);
    logic [67:0] d;
    d = {fill, fill, fill[3:0]};
    d[25:21] = id; d[20:19] = tgt;
    return d;
  endfunction

  task automatic load_cfg(logic [14:0] a, logic [LEN_W-1:0] l);
    @(negedge clk); cfg_load = 1; cfg_addr = a; cfg_len = l;
    @(negedge clk); cfg_load = 0;
  endtask

  task automatic issue(logic [2:0] c, logic [4:0] id, logic [1:0] tgt, logic [31:0] fill, int wait_cyc);
    @(negedge clk); cmd_valid = 1; cmd = c; dq_in = mk_dq(id, tgt, fill);
    @(negedge clk); cmd_valid = 0; dq_in = '0;
    repeat (wait_cyc) @(negedge clk);
  endtask

  task automatic expect_pulses(string tag, int exp);
    checks++;
    if (ack_pulses != exp) begin
      errors++;
      $display("FAIL %s ack pulse count: actual %0d expected %0d", tag, ack_pulses, exp);
    end
    ack_pulses = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R11: preload both arrays through the preload port
    for (int i = 0; i < DEPTH; i++) begin
      ref_dat[i] = {4'hD, 32'(i * 32'h01010101 + 7), 32'(~i)};
      ref_msk[i] = {4'h3, 32'(i * 32'h13579BDF), 32'(i + 100)};
    end
    for (int i = 0; i < 2*DEPTH; i++) begin
      @(negedge clk);
      pre_we = 1; pre_mask = (i >= DEPTH); pre_idx = IDX_W'(i % DEPTH);
      pre_data = (i >= DEPTH) ? ref_msk[i % DEPTH] : ref_dat[i % DEPTH];
    end
    @(negedge clk); pre_we = 0;
    ack_pulses = 0;

    cur_tag = "R1 R11 data burst";
    load_cfg(15'd3, 4'd4);
    issue(3'b100, MY_ID, 2'b00, 32'hDEADBEEF, 16);
    expect_pulses("R1", 4);

    cur_tag = "R7 mask burst continues location";
    issue(3'b100, MY_ID, 2'b01, 32'h5A5A5A5A, 16);
    expect_pulses("R7", 4);

    cur_tag = "R8 zero length";
    load_cfg(15'd9, 4'd0);
    issue(3'b100, MY_ID, 2'b00, 32'h0, 8);
    expect_pulses("R8", 1);

    cur_tag = "R2 broadcast to last device";
    load_cfg(15'd1, 4'd2);
    last_dev = 1;
    issue(3'b100, 5'h1F, 2'b01, 32'h12345678, 10);
    expect_pulses("R2", 2);
    last_dev = 0;
    cur_tag = "R2 broadcast not last";
    issue(3'b100, 5'h1F, 2'b00, 32'h1, 10);
    expect_pulses("R2", 0);
    cur_tag = "R2 wrong id";
    issue(3'b100, 5'h0B, 2'b00, 32'h2, 10);
    expect_pulses("R2", 0);

    cur_tag = "R1 rejected codes";
    issue(3'b000, MY_ID, 2'b00, 32'h3, 6);
    issue(3'b101, MY_ID, 2'b00, 32'h3, 6);
    issue(3'b110, MY_ID, 2'b00, 32'h3, 6);
    issue(3'b100, MY_ID, 2'b10, 32'h3, 6);
    issue(3'b100, MY_ID, 2'b11, 32'h3, 6);
    expect_pulses("R1", 0);

    cur_tag = "R7 location wrap";
    load_cfg(15'h7FFE, 4'd3);
    issue(3'b100, MY_ID, 2'b00, 32'hFFFFFFFF, 14);
    expect_pulses("R7", 3);

    cur_tag = "R9 R10 mid-burst command and load";
    load_cfg(15'd5, 4'd5);
    issue(3'b100, MY_ID, 2'b01, 32'hCAFE0000, 2);
    @(negedge clk); cmd_valid = 1; cmd = 3'b100; dq_in = mk_dq(MY_ID, 2'b00, 32'h0);
    cfg_load = 1; cfg_addr = 15'd12; cfg_len = 4'd1;
    @(negedge clk); cmd_valid = 0; cfg_load = 0; dq_in = '0;
    repeat (14) @(negedge clk);
    expect_pulses("R9", 5);
    cur_tag = "R10 length kept after ignored load";
    issue(3'b100, MY_ID, 2'b00, 32'h0, 16);
    expect_pulses("R10", 5);

    cur_tag = "R6 back-to-back";
    load_cfg(15'd2, 4'd1);
    issue(3'b100, MY_ID, 2'b00, 32'h0, 5);
    issue(3'b100, MY_ID, 2'b01, 32'h0, 8);
    expect_pulses("R6", 2);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule